// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state without software help. After a single start pulse it walks a fixed bring-up order through a command interface shared with the SDRAM command engine. It enables the memory clock, waits a programmable settle time, precharges all banks, requests two auto-refresh commands of four refreshes each, and loads the mode register. It then presents the periodic refresh interval to the refresh timer and raises `done` once the command engine is idle again.

The command engine reports that it is occupied through `busy`. The sequencer issues each step only in the cycle after it has sampled `busy` low. It never samples `busy` in the cycle immediately after a strobe, so the engine has one cycle to raise it. The settle wait is a cycle counter whose length is a parameter. The refresh interval is derived at elaboration time from the SDRAM clock frequency, the retention time and the row count, with a fixed margin subtracted.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset `cmdValid`, `refreshLoad` and `done` are low and `cmdWord` and `refreshWord` are zero.
- R2: Once started, the commands appear in this order, each as a one-cycle `cmdValid` pulse: clock enable (code 1), precharge all (code 2), auto-refresh (code 3), auto-refresh (code 3), load mode (code 4). Then `refreshLoad` pulses for one cycle, and never in the same cycle as `cmdValid`. The command word packs the code in bits 2:0, the refresh count minus one in bits 6:3 and the mode value in bits 19:7.
- R3: Each auto-refresh command carries the value 3 in bits 6:3, which requests four refreshes, eight over the whole sequence. Every other command carries zero there.
- R4: The load mode command carries the mode value 0x231 in bits 19:7, made up of burst length two (bits 2:0 = 1), sequential bursts (bit 3 = 0), CAS latency three (bits 6:4 = 3), standard operation (bits 8:7 = 0) and single-location write bursts (bit 9 = 1). All other commands carry zero there, and `cmdWord` is zero whenever `cmdValid` is low.
- R5: A command or refresh load is strobed only in the cycle after a clock edge at which `busy` was low. `busy` is first sampled two cycles after the previous strobe, or one cycle after the start pulse.
- R6: The precharge-all strobe follows the clock-enable strobe by at least `WAIT_CYCLES`+2 cycles, and by exactly that when `busy` stays low.
- R7: `refreshWord` takes the value `(SDCLK_KHZ*RETENTION_US/(ROWS*1000) - MARGIN)` shifted left by one bit in the cycle `refreshLoad` pulses, and holds it until reset. With the defaults this is 1386, giving a word of 2772.
- R8: `done` rises in the cycle after the first edge, two or more cycles after the refresh load, at which `busy` is low. It then stays high until reset.
- R9: A start pulse while the sequence runs or after `done` has no effect. No further strobes appear and the order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts the sequence when the block is idle |
| busy | input | 1 | Command engine occupied; the next step waits while high |
| cmdWord | output | 20 | Command code, refresh count minus one, mode value; zero when not valid |
| cmdValid | output | 1 | One-cycle strobe qualifying `cmdWord` |
| refreshWord | output | REF_W+1 | Refresh interval count shifted left by one |
| refreshLoad | output | 1 | One-cycle strobe loading `refreshWord` into the refresh timer |
| done | output | 1 | Memory initialized; sticky until reset |

## Verification
A step counter that skips or repeats shows up as a wrong code or a missing pulse on `cmdWord` at the very next strobe. A handshake fault shows up as a strobe in a cycle where `busy` had just been sampled high, or as a strobe arriving one cycle early or late. A settle counter that is off by one moves the precharge strobe by exactly that amount. Because the expected strobes are recomputed every cycle from the inputs alone, such faults appear within one cycle of the first divergent edge and are not deferred to the end of the sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int CODE_W = 3;
  localparam int NREF_W = 4;
  localparam int MODE_W = 13;
  localparam int CMD_W  = CODE_W + NREF_W + MODE_W;

  typedef enum logic [CODE_W-1:0] {
    CMD_NONE       = 3'd0,
    CMD_CLK_ON     = 3'd1,
    CMD_PRECHG_ALL = 3'd2,
    CMD_AUTO_RFSH  = 3'd3,
    CMD_LOAD_MODE  = 3'd4
  } seqCmd_e;

  typedef enum logic [2:0] {
    STEP_CLK_ON,
    STEP_PRECHG,
    STEP_RFSH_A,
    STEP_RFSH_B,
    STEP_LOAD_MODE,
    STEP_RFSH_TIMER
  } initStep_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [NREF_W-1:0] nref;
    seqCmd_e           code;
  } cmdWord_t;

  typedef struct packed {
    logic      issueCmd;
    logic      issueRefresh;
    logic      finish;
    logic      delayLoad;
    logic      delayTick;
    initStep_e step;
  } seqStrobes_t;

  // mode value fields: write burst single, op mode, CAS, burst type, burst length
  localparam logic [2:0] MODE_BLEN2   = 3'b001;
  localparam logic       MODE_SEQ     = 1'b0;
  localparam logic [2:0] MODE_CAS3    = 3'd3;
  localparam logic [1:0] MODE_OPSTD   = 2'b00;
  localparam logic       MODE_WBSING  = 1'b1;
  localparam logic [MODE_W-1:0] MODE_VALUE =
    {3'b000, MODE_WBSING, MODE_OPSTD, MODE_CAS3, MODE_SEQ, MODE_BLEN2};

  function automatic initStep_e stepAfter(initStep_e s);
    case (s)
      STEP_CLK_ON:    return STEP_PRECHG;
      STEP_PRECHG:    return STEP_RFSH_A;
      STEP_RFSH_A:    return STEP_RFSH_B;
      STEP_RFSH_B:    return STEP_LOAD_MODE;
      default:        return STEP_RFSH_TIMER;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        busy,
  input  logic        delayDone,
  output seqStrobes_t strobes
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_HOLD,
    S_DELAY,
    S_FINAL,
    S_DONE
  } ctrlState_e;

  ctrlState_e state, stateNext;
  initStep_e  step, stepNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      step  <= STEP_CLK_ON;
    end else begin
      state <= stateNext;
      step  <= stepNext;
    end
  end

  always_comb begin
    stateNext    = state;
    stepNext     = step;
    strobes      = '0;
    strobes.step = step;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stateNext = S_WAIT;
          stepNext  = STEP_CLK_ON;
        end
      end
      S_WAIT: begin
        if (!busy) begin
          if (step == STEP_RFSH_TIMER) strobes.issueRefresh = 1'b1;
          else                         strobes.issueCmd     = 1'b1;
          stateNext = S_HOLD;
        end
      end
      S_HOLD: begin
        // strobe cycle: busy is not yet meaningful
        if (step == STEP_RFSH_TIMER) begin
          stateNext = S_FINAL;
        end else if (step == STEP_CLK_ON) begin
          strobes.delayLoad = 1'b1;
          stateNext = S_DELAY;
          stepNext  = stepAfter(step);
        end else begin
          stateNext = S_WAIT;
          stepNext  = stepAfter(step);
        end
      end
      S_DELAY: begin
        strobes.delayTick = 1'b1;
        if (delayDone) stateNext = S_WAIT;
      end
      S_FINAL: begin
        if (!busy) begin
          strobes.finish = 1'b1;
          stateNext = S_DONE;
        end
      end
      S_DONE: stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int          WAIT_CYCLES = 900000,
  parameter int          AR_PER_CMD  = 4,
  parameter int          REF_W       = 13,
  parameter logic [REF_W:0] REF_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  output logic              delayDone,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  output logic [REF_W:0]    refreshWord,
  output logic              refreshLoad,
  output logic              done
);

  localparam logic [NREF_W-1:0] NREF_FIELD = NREF_W'(AR_PER_CMD - 1);

  generate
    if (WAIT_CYCLES <= 1) begin : g_noDelay
      assign delayDone = 1'b1;
    end else begin : g_delayCnt
      localparam int DLY_W = $clog2(WAIT_CYCLES);
      localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(WAIT_CYCLES - 1);
      logic [DLY_W-1:0] delayCnt;
      always_ff @(posedge clk) begin
        if (rst)                                   delayCnt <= '0;
        else if (strobes.delayLoad)                delayCnt <= DLY_LOAD;
        else if (strobes.delayTick && delayCnt != '0) delayCnt <= delayCnt - 1'b1;
      end
      assign delayDone = (delayCnt == '0);
    end
  endgenerate

  cmdWord_t stepWord;

  always_comb begin
    stepWord = '0;
    unique case (strobes.step)
      STEP_CLK_ON:    stepWord.code = CMD_CLK_ON;
      STEP_PRECHG:    stepWord.code = CMD_PRECHG_ALL;
      STEP_RFSH_A,
      STEP_RFSH_B: begin
        stepWord.code = CMD_AUTO_RFSH;
        stepWord.nref = NREF_FIELD;
      end
      STEP_LOAD_MODE: begin
        stepWord.code = CMD_LOAD_MODE;
        stepWord.mode = MODE_VALUE;
      end
      default:        stepWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdValid    <= 1'b0;
      cmdWord     <= '0;
      refreshLoad <= 1'b0;
      refreshWord <= '0;
      done        <= 1'b0;
    end else begin
      cmdValid    <= strobes.issueCmd;
      cmdWord     <= strobes.issueCmd ? stepWord : '0;
      refreshLoad <= strobes.issueRefresh;
      if (strobes.issueRefresh) refreshWord <= REF_WORD;
      if (strobes.finish)       done <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYCLES  = 900000,
  parameter int SDCLK_KHZ    = 90000,
  parameter int RETENTION_US = 64000,
  parameter int ROWS         = 4096,
  parameter int MARGIN       = 20,
  parameter int AR_PER_CMD   = 4,
  parameter int REF_W        = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  output logic [REF_W:0]    refreshWord,
  output logic              refreshLoad,
  output logic              done
);

  localparam longint REF_COUNT =
    (longint'(SDCLK_KHZ) * longint'(RETENTION_US)) / (longint'(ROWS) * 1000) - longint'(MARGIN);
  localparam logic [REF_W:0] REF_WORD = {REF_W'(REF_COUNT), 1'b0};

  seqStrobes_t strobes;
  logic        delayDone;

  sdram_init_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .delayDone (delayDone),
    .strobes   (strobes)
  );

  sdram_init_dp #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .AR_PER_CMD  (AR_PER_CMD),
    .REF_W       (REF_W),
    .REF_WORD    (REF_WORD)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .delayDone   (delayDone),
    .cmdWord     (cmdWord),
    .cmdValid    (cmdValid),
    .refreshWord (refreshWord),
    .refreshLoad (refreshLoad),
    .done        (done)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic [CMD_W-1:0] cmdWord,
  input logic             cmdValid,
  input logic             refreshLoad,
  input logic             done
);

  cmdWord_t w;
  assign w = cmdWord;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);                                        // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && refreshLoad));                                    // R2
  AST_NREF_ONLY_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && w.code != CMD_AUTO_RFSH) |-> w.nref == '0);        // R3
  AST_WORD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |-> cmdWord == '0);                                   // R4
  AST_MODE_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && w.code != CMD_LOAD_MODE) |-> w.mode == '0);        // R4
  AST_ISSUE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmdValid || refreshLoad) |-> !$past(busy));                    // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done);                                                 // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cmdValid && !refreshLoad));                          // R9

endmodule

bind sdram_init_seq sdram_init_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .cmdWord     (cmdWord),
  .cmdValid    (cmdValid),
  .refreshLoad (refreshLoad),
  .done        (done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam int WAITC = 12;
  localparam int KHZ = 90000, RET = 64000, NROWS = 4096, MARG = 20, RW = 13;
  localparam longint REF_EXP = ((longint'(KHZ) * RET) / (longint'(NROWS) * 1000) - MARG) * 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic [19:0] cmdWord;
  logic        cmdValid;
  logic [RW:0] refreshWord;
  logic        refreshLoad;
  logic        done;

  always #4 clk = ~clk;

  sdram_init_seq #(.WAIT_CYCLES(WAITC), .SDCLK_KHZ(KHZ), .RETENTION_US(RET),
                   .ROWS(NROWS), .MARGIN(MARG), .REF_W(RW)) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .cmdWord(cmdWord),
    .cmdValid(cmdValid), .refreshWord(refreshWord), .refreshLoad(refreshLoad), .done(done));

  int nVec = 0, nFail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int cyc = 0;
  int mStep = -1;   // -1 idle, 0..4 commands, 5 refresh load, 6 finish, 7 complete
  int earliest = 0;
  bit eValid = 0, eLoad = 0, eDone = 0;
  logic [19:0] eWord = '0;
  logic [RW:0] eRef = '0;
  bit armed = 0;

  function automatic logic [19:0] wordFor(int s);
    case (s)
      0: return 20'd1;
      1: return 20'd2;
      2, 3: return {13'd0, 4'd3, 3'd3};
      default: return {13'h231, 4'd0, 3'd4};
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    eValid = 0; eLoad = 0; eWord = '0;
    if (rst) begin
      mStep = -1; eRef = '0; eDone = 0;
    end else if (mStep == -1) begin
      if (start) begin mStep = 0; earliest = cyc + 1; end
    end else if (mStep <= 6 && cyc >= earliest && !busy) begin
      if (mStep < 5) begin
        eValid = 1; eWord = wordFor(mStep);
        earliest = cyc + 2 + ((mStep == 0) ? WAITC : 0);
      end else if (mStep == 5) begin
        eLoad = 1; eRef = (RW+1)'(REF_EXP); earliest = cyc + 2;
      end else begin
        eDone = 1;
      end
      mStep++;
    end
    armed = 1;
  end

  always @(negedge clk) if (armed) begin
    check(cmdValid === eValid, "R5", "cmdValid", cmdValid, eValid);
    check(cmdWord === eWord, "R4", "cmdWord", cmdWord, eWord);
    check(refreshLoad === eLoad, "R5", "refreshLoad", refreshLoad, eLoad);
    check(refreshWord === eRef, "R7", "refreshWord", refreshWord, eRef);
    check(done === eDone, "R8", "done", done, eDone);
  end

  // ---------------- busy responder and observers ----------------
  int busyLat = 0, busyCnt = 0;
  bit forceBusy = 0;
  int codes[$];
  int ckeAt = 0, pallAt = 0, strobesSeen = 0;

  always @(negedge clk) begin
    if (cmdValid === 1'b1) begin
      codes.push_back(int'(cmdWord[2:0]));
      if (cmdWord[2:0] == 3'd1) ckeAt = cyc;
      if (cmdWord[2:0] == 3'd2) pallAt = cyc;
    end
    if (cmdValid === 1'b1 || refreshLoad === 1'b1) strobesSeen++;
    if (busyLat > 0 && (cmdValid === 1'b1 || refreshLoad === 1'b1)) busyCnt = busyLat;
    else if (busyCnt > 0) busyCnt--;
    busy <= forceBusy || (busyCnt > 0);
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    check(done === 1'b1, req, "done reached", done, 1);
  endtask

  task automatic checkOrder();
    int expCodes[6] = '{1, 2, 3, 3, 4, 0};
    check(codes.size() == 5, "R2", "command count", codes.size(), 5);
    for (int i = 0; i < 5 && i < codes.size(); i++)
      check(codes[i] == expCodes[i], "R2", "command code order", codes[i], expCodes[i]);
  endtask

  task automatic checkReset();
    check(cmdValid === 1'b0 && refreshLoad === 1'b0, "R1", "strobes low", {cmdValid, refreshLoad}, 0);
    check(done === 1'b0, "R1", "done low", done, 0);
    check(cmdWord === '0 && refreshWord === '0, "R1", "words zero", cmdWord, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkReset();

    // Run A: busy never raised, exact settle gap (R2 R3 R4 R6 R7)
    codes.delete(); busyLat = 0;
    pulseStart();
    waitDone("R8");
    checkOrder();
    check(pallAt - ckeAt == WAITC + 2, "R6", "settle gap exact", pallAt - ckeAt, WAITC + 2);
    check(refreshWord == (RW+1)'(REF_EXP), "R7", "refresh word", refreshWord, REF_EXP);

    // After done: start ignored, done held (R9 R8)
    strobesSeen = 0;
    pulseStart();
    repeat (40) @(negedge clk);
    check(strobesSeen == 0, "R9", "strobes after done", strobesSeen, 0);
    check(done === 1'b1, "R8", "done sticky", done, 1);

    // Run B: busy held before first command, engine busy 3 cycles, stray start (R5 R9)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    codes.delete(); busyLat = 3; forceBusy = 1;
    pulseStart();
    repeat (5) @(negedge clk);
    check(strobesSeen == 0 && cmdValid === 1'b0, "R5", "no issue while busy", cmdValid, 0);
    forceBusy = 0;
    repeat (20) @(negedge clk);
    pulseStart();
    waitDone("R8");
    checkOrder();
    check(pallAt - ckeAt >= WAITC + 2, "R6", "settle gap minimum", pallAt - ckeAt, WAITC + 2);

    // Reset in the middle of the settle wait (R1), then a run with long busy (R8)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    codes.delete(); busyLat = 1;
    pulseStart();
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checkReset();
    codes.delete(); busyLat = 7;
    pulseStart();
    waitDone("R8");
    checkOrder();
    check(refreshWord == (RW+1)'(REF_EXP), "R7", "refresh word held", refreshWord, REF_EXP);
    repeat (5) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule